// File: doc/BRIEF.md
# Packed-Control Performance Monitor

This block counts processor activity for profiling. It holds one free-running cycle counter and two event counters, each 32 bits wide. Events arrive as a vector of single-cycle pulses, one bit per 8-bit event code. Each event counter follows the code chosen in its select field and advances in any cycle where that code's bit is high. A prescale mode makes the cycle counter advance once every 64 clocks instead of once per clock.

All configuration and status share one packed 32-bit control word. It holds the global run bit, two self-clearing counter-reset bits, the prescale mode, three interrupt enables, three sticky overflow flags and the two event-select fields. Software reaches the control word and the three counters through a small register port. A write takes effect at the next clock edge. A read returns the addressed register combinationally. A counter that wraps past its maximum sets its overflow flag. Each flag stays set until software writes a 1 to it. One level-sensitive interrupt combines the flags with their enables.

Top module: `perfmon_unit`

## Requirements
- R1: After a synchronous reset, all four registers read as zero and `irq` is low.
- R2: Register addresses are 0 for the control word, 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1. The control word has these fields: run at bit 0, prescale mode at bit 3, interrupt enables at bits 4, 5 and 6 (event 0, event 1, cycle), event-0 select at bits 19:12 and event-1 select at bits 27:20. Each field reads back as written.
- R3: Control bits 7, 11 and 31:28 always read as 0, and so do the reset bits 1 and 2.
- R4: Writing the control word with bit 1 set clears both event counters at that edge. Writing it with bit 2 set clears the cycle counter and the prescaler at that edge. Either clear overrides counting.
- R5: While the run bit is 0, no counter advances, whatever the event inputs do.
- R6: While running with bit 3 at 0, the cycle counter advances by one every clock. With bit 3 at 1, it advances once per 64 clocks: first 64 clocks after its clear.
- R7: An event counter advances by one in each running cycle in which `evt_vec[select]` is high. Select code 0xFF never counts. Pulses on codes that are not selected have no effect.
- R8: A write to a counter address loads that counter with the write data at that edge. The load takes priority over counting.
- R9: When a counter steps from 0xFFFFFFFF to 0, its overflow flag is set at the same edge. The flags sit at bit 8 (event 0), bit 9 (event 1) and bit 10 (cycle).
- R10: An overflow flag stays set until cleared. A new overflow on another counter leaves it set, and so does writing 0 to its bit.
- R11: Writing 1 to a flag bit clears it, so writing back a value just read clears every flag that was set.
- R12: `irq` is high exactly when at least one overflow flag is set together with its interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 32 | Write data |
| evt_vec | input | 256 | Event pulses, one bit per event code |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume that reset is held low through the first clock edge. They also assume that any write to the register port is marked by `reg_we`, so that idle cycles with `reg_we` low can change the counters only through counting. Hold and step properties are therefore conditioned on `reg_we` being low. The bench drives every write, read address and event pulse on the falling edge and releases each strobe one cycle later, so a write never spans two rising edges. Every counter value the bench expects is derived by counting the rising edges between its own write and its own sample.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
    // Field positions inside the packed control word; software decodes these.
    localparam int CB_RUN     = 0;
    localparam int CB_EVRST   = 1;
    localparam int CB_CYRST   = 2;
    localparam int CB_DIV     = 3;
    localparam int CB_IE_LO   = 4;
    localparam int CB_OVF_LO  = 8;
    localparam int CB_SEL0_LO = 12;
    localparam int CB_SEL1_LO = 20;

    localparam int NUM_SRC  = 3;
    localparam int NUM_EV   = 2;
    localparam int SRC_CYC  = 2;

    localparam int CODE_W   = 8;
    localparam logic [CODE_W-1:0] CODE_NONE = 8'hFF;

    typedef logic [1:0] reg_addr_t;
    localparam reg_addr_t ADDR_CTRL = 2'd0;
    localparam reg_addr_t ADDR_CYC  = 2'd1;
    localparam reg_addr_t ADDR_EV0  = 2'd2;
endpackage

// File: rtl/perfmon_ctrl.sv
// Packed control/status state of the monitor.
// Holds run, prescale mode, interrupt enables, event selects and sticky
// overflow flags. Assumes the caller has already split the write data
// into fields. Flags use write-one-to-clear; a wrap in the same cycle wins.
module perfmon_ctrl
    import perfmon_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_run,
    input  logic                            wr_div,
    input  logic [NUM_SRC-1:0]              wr_ie,
    input  logic [NUM_SRC-1:0]              wr_clr,
    input  logic [NUM_EV-1:0][CODE_W-1:0]   wr_sel,
    input  logic [NUM_SRC-1:0]              wrap,
    output logic                            run,
    output logic                            div_mode,
    output logic [NUM_SRC-1:0]              ie,
    output logic [NUM_SRC-1:0]              flags,
    output logic [NUM_EV-1:0][CODE_W-1:0]   sel
);
    logic [NUM_SRC-1:0] clr_mask;

    // Clear mask applies only on a control write.
    always_comb clr_mask = wr_en ? wr_clr : '0;

    // Configuration fields load on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            div_mode <= 1'b0;
            ie       <= '0;
            sel      <= '0;
        end else if (wr_en) begin
            run      <= wr_run;
            div_mode <= wr_div;
            ie       <= wr_ie;
            sel      <= wr_sel;
        end
    end

    // Sticky overflow flags: set on wrap, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | wrap;
    end
endmodule

// File: rtl/perfmon_counter.sv
// One loadable up-counter with wrap detection.
// Clear beats load beats increment. Wrap is reported combinationally
// in the cycle the counter steps from all ones to zero.
module perfmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    // Wrap only when an increment really happens on a full count.
    always_comb wrap = inc && !clr && !ld && (&cnt);

    // Count register with clear/load/increment priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/perfmon_prescale.sv
// Cycle-counter step generator.
// In direct mode it steps every running cycle; in divide mode it steps
// once per 2**LOG2 running cycles. Assumes clr comes with the counter clear.
module perfmon_prescale #(
    parameter int LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic div_mode,
    output logic tick
);
    logic [LOG2-1:0] pre;

    // Step when running, either directly or at the prescaler's terminal count.
    always_comb tick = run && !clr && (!div_mode || (&pre));

    // Prescaler advances only while running in divide mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pre <= '0;
        else if (clr)                 pre <= '0;
        else if (run && div_mode)     pre <= pre + 1'b1;
    end
endmodule

// File: rtl/perfmon_evt_match.sv
// Event selector for one counter: picks the pulse bit of the chosen code.
// Assumes pulses are one cycle wide; the null code never matches.
module perfmon_evt_match
    import perfmon_pkg::*;
#(
    parameter int NCODES = 256
) (
    input  logic [CODE_W-1:0] sel,
    input  logic [NCODES-1:0] evt_vec,
    input  logic              run,
    output logic              hit
);
    // Index the pulse vector by the select code.
    always_comb hit = run && (sel != CODE_NONE) && evt_vec[sel];
endmodule

// File: rtl/perfmon_unit.sv
// Performance monitor top: cycle counter, two event counters and a packed
// control word behind a small register port. Assumes writes are one-cycle
// strobes and reads are combinational on reg_addr.
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PRE_LOG2  = 6,
    localparam int NCODES   = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NCODES-1:0] evt_vec,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic                          ctrl_we, ev_rst, cy_rst;
    logic                          glob_en, div_mode, cyc_tick;
    logic [NUM_SRC-1:0]            irq_en, ovf_flags, wrap_v;
    logic [NUM_EV-1:0][CODE_W-1:0] sel, wr_sel;
    logic [NUM_EV-1:0]             hit;
    logic [NUM_EV-1:0][DATA_W-1:0] ev_cnt;
    logic [DATA_W-1:0]             cyc_cnt, ctrl_word;

    // Decode control-word write and its self-clearing reset bits.
    always_comb begin
        ctrl_we   = reg_we && (reg_addr == ADDR_CTRL);
        ev_rst    = ctrl_we && reg_wdata[CB_EVRST];
        cy_rst    = ctrl_we && reg_wdata[CB_CYRST];
        wr_sel[0] = reg_wdata[CB_SEL0_LO +: CODE_W];
        wr_sel[1] = reg_wdata[CB_SEL1_LO +: CODE_W];
    end

    perfmon_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_we),
        .wr_run   (reg_wdata[CB_RUN]),
        .wr_div   (reg_wdata[CB_DIV]),
        .wr_ie    (reg_wdata[CB_IE_LO +: NUM_SRC]),
        .wr_clr   (reg_wdata[CB_OVF_LO +: NUM_SRC]),
        .wr_sel   (wr_sel),
        .wrap     (wrap_v),
        .run      (glob_en),
        .div_mode (div_mode),
        .ie       (irq_en),
        .flags    (ovf_flags),
        .sel      (sel)
    );

    genvar j;
    generate
        for (j = 0; j < NUM_EV; j++) begin : g_ev
            localparam reg_addr_t MY_ADDR = ADDR_EV0 + reg_addr_t'(j);
            perfmon_evt_match #(.NCODES(NCODES)) match_i (
                .sel     (sel[j]),
                .evt_vec (evt_vec),
                .run     (glob_en),
                .hit     (hit[j])
            );
            perfmon_counter #(.W(DATA_W)) cnt_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (ev_rst),
                .ld     (reg_we && (reg_addr == MY_ADDR)),
                .ld_val (reg_wdata),
                .inc    (hit[j]),
                .cnt    (ev_cnt[j]),
                .wrap   (wrap_v[j])
            );
        end
    endgenerate

    perfmon_prescale #(.LOG2(PRE_LOG2)) pre_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cy_rst),
        .run      (glob_en),
        .div_mode (div_mode),
        .tick     (cyc_tick)
    );

    perfmon_counter #(.W(DATA_W)) cyc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cy_rst),
        .ld     (reg_we && (reg_addr == ADDR_CYC)),
        .ld_val (reg_wdata),
        .inc    (cyc_tick),
        .cnt    (cyc_cnt),
        .wrap   (wrap_v[SRC_CYC])
    );

    // Assemble the readable control word; holes and reset bits stay zero.
    always_comb begin
        ctrl_word                             = '0;
        ctrl_word[CB_RUN]                     = glob_en;
        ctrl_word[CB_DIV]                     = div_mode;
        ctrl_word[CB_IE_LO +: NUM_SRC]        = irq_en;
        ctrl_word[CB_OVF_LO +: NUM_SRC]       = ovf_flags;
        ctrl_word[CB_SEL0_LO +: CODE_W]       = sel[0];
        ctrl_word[CB_SEL1_LO +: CODE_W]       = sel[1];
    end

    // Read multiplexer over the four registers.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_word;
            ADDR_CYC:  reg_rdata = cyc_cnt;
            ADDR_EV0:  reg_rdata = ev_cnt[0];
            default:   reg_rdata = ev_cnt[1];
        endcase
    end

    // Level interrupt from enabled flags.
    always_comb irq = |(ovf_flags & irq_en);
endmodule

// File: rtl/perfmon_unit_chk.sv
// Property checker for perfmon_unit, attached by bind.
module perfmon_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        irq,
    input logic [2:0]  flags,
    input logic [2:0]  ie,
    input logic        run,
    input logic        div,
    input logic [31:0] cyc
);
    genvar i;
    generate
        for (i = 0; i < 3; i++) begin : g_flag
            // R10
            flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                flags[i] && !(reg_we && reg_addr == 2'd0 && reg_wdata[8+i]) |=> flags[i]);
        end
    endgenerate

    // R12
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != 3'b000) && (ie != 3'b000));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !reg_we |=> $stable(cyc));

    // R6
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !div && !reg_we |=> cyc == $past(cyc) + 32'd1);

    // R9
    cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !div && (&cyc) && !reg_we |=> flags[2]);

    // R3
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd0 |-> reg_rdata[31:28] == 4'd0 && !reg_rdata[11]
                             && !reg_rdata[7] && reg_rdata[2:1] == 2'd0);
endmodule

bind perfmon_unit perfmon_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .flags     (ovf_flags),
    .ie        (irq_en),
    .run       (glob_en),
    .div       (div_mode),
    .cyc       (cyc_cnt)
);

// File: tb/perfmon_unit_tb_top.sv
module perfmon_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [31:0]  reg_wdata = '0;
    logic [255:0] evt_vec = '0;
    logic [31:0]  reg_rdata;
    logic         irq;
    int           n_chk = 0;
    int           n_err = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    perfmon_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .evt_vec(evt_vec), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the write edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Combinational read at the current time.
    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse(input int code);
        @(negedge clk);
        evt_vec[code] = 1'b1;
        @(negedge clk);
        evt_vec = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg after reset", v, 32'h0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_cycle;
        logic [31:0] v;
        wr(2'd0, 32'h0FF0_0007);
        idle(10);
        rd(2'd1, v);
        chk("R6 cycle count direct", v, 32'd10);
        wr(2'd0, 32'h0FF0_0000);
        rd(2'd1, v);
        chk("R6 count up to stop", v, 32'd12);
        idle(5);
        rd(2'd1, v);
        chk("R5 cycle held while stopped", v, 32'd12);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        wr(2'd0, 32'h0FF0_000D);
        rd(2'd1, v);
        chk("R4 cycle clear on write", v, 32'd0);
        idle(63);
        rd(2'd1, v);
        chk("R6 div mode 63 clocks", v, 32'd0);
        idle(1);
        rd(2'd1, v);
        chk("R6 div mode 64 clocks", v, 32'd1);
        idle(64);
        rd(2'd1, v);
        chk("R6 div mode 128 clocks", v, 32'd2);
        wr(2'd0, 32'h0FF0_0000);
    endtask

    task automatic t_events;
        logic [31:0] v;
        wr(2'd0, 32'h0050_7003);
        repeat (3) pulse(8'h07);
        pulse(8'h05);
        repeat (2) pulse(8'h06);
        @(negedge clk);
        evt_vec[8'h07] = 1'b1; evt_vec[8'h05] = 1'b1;
        @(negedge clk);
        evt_vec = '0;
        rd(2'd2, v);
        chk("R7 event0 count", v, 32'd4);
        rd(2'd3, v);
        chk("R7 event1 count", v, 32'd2);
        rd(2'd0, v);
        chk("R2 control readback", v, 32'h0050_7001);
    endtask

    task automatic t_null_and_stop;
        logic [31:0] v;
        wr(2'd0, 32'h0FF0_0003);
        rd(2'd2, v);
        chk("R4 event clear", v, 32'd0);
        repeat (3) pulse(8'hFF);
        rd(2'd2, v);
        chk("R7 null code event0", v, 32'd0);
        rd(2'd3, v);
        chk("R7 null code event1", v, 32'd0);
        wr(2'd0, 32'h0050_7000);
        pulse(8'h07);
        pulse(8'h05);
        rd(2'd2, v);
        chk("R5 event0 stopped", v, 32'd0);
        rd(2'd3, v);
        chk("R5 event1 stopped", v, 32'd0);
    endtask

    task automatic t_load;
        logic [31:0] v;
        wr(2'd1, 32'h1234_5678);
        rd(2'd1, v);
        chk("R8 cycle load", v, 32'h1234_5678);
        wr(2'd2, 32'hA5A5_0001);
        rd(2'd2, v);
        chk("R8 event0 load", v, 32'hA5A5_0001);
        wr(2'd0, 32'h0FF0_0001);
        wr(2'd1, 32'hCAFE_0000);
        rd(2'd1, v);
        chk("R8 load beats count", v, 32'hCAFE_0000);
        wr(2'd0, 32'h0FF0_0000);
    endtask

    task automatic t_wrap_flags;
        logic [31:0] v;
        wr(2'd2, 32'hFFFF_FFFE);
        wr(2'd0, 32'h0FF0_B011);
        pulse(8'h0B);
        rd(2'd0, v);
        chk("R9 no flag before wrap", v, 32'h0FF0_B011);
        pulse(8'h0B);
        rd(2'd2, v);
        chk("R9 event0 wrapped", v, 32'd0);
        rd(2'd0, v);
        chk("R9 event0 flag", v, 32'h0FF0_B111);
        chk("R12 irq on enabled flag", {31'd0, irq}, 32'd1);
        pulse(8'h0B);
        wr(2'd0, 32'h0FF0_B011);
        rd(2'd0, v);
        chk("R10 flag kept on zero write", v, 32'h0FF0_B111);
        wr(2'd0, 32'h0FF0_B010);
        wr(2'd1, 32'hFFFF_FFFD);
        wr(2'd0, 32'h0FF0_B051);
        idle(2);
        rd(2'd0, v);
        chk("R9 cycle flag not yet", v, 32'h0FF0_B151);
        idle(1);
        rd(2'd0, v);
        chk("R10 both flags set", v, 32'h0FF0_B551);
        wr(2'd0, 32'h0FF0_B451);
        rd(2'd0, v);
        chk("R11 clear only cycle flag", v, 32'h0FF0_B151);
        rd(2'd0, v);
        wr(2'd0, v);
        rd(2'd0, v);
        chk("R11 write back clears", v, 32'h0FF0_B051);
        chk("R12 irq low after clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_irq_mask;
        logic [31:0] v;
        wr(2'd0, 32'h0FF0_B000);
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd0, 32'h006F_F001);
        pulse(8'h06);
        rd(2'd0, v);
        chk("R9 event1 flag", v, 32'h006F_F201);
        chk("R12 irq masked", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h006F_F021);
        chk("R12 irq after enable", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_holes;
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v);
        chk("R3 holes and reset bits zero", v, 32'h0FFF_F079);
        chk("R11 all-ones clears irq", {31'd0, irq}, 32'd0);
        rd(2'd1, v);
        chk("R4 cycle cleared", v, 32'd0);
        rd(2'd2, v);
        chk("R4 event0 cleared", v, 32'd0);
        rd(2'd3, v);
        chk("R4 event1 cleared", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cycle();
        t_prescale();
        t_events();
        t_null_and_stop();
        t_load();
        t_wrap_flags();
        t_irq_mask();
        t_holes();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule